// File: doc/BRIEF.md
# Lockable Watchdog Timer with Pretimeout

This block is a watchdog peripheral driven by a slow real-time tick. A 32-bit down-counter is reloaded from a programmed timeout and compared with a programmed early-warning threshold. When the count falls to that threshold, a sticky status flag is set and an interrupt may be raised. When the count reaches zero, a one-cycle reset request is sent to the system reset controller. Every counter value is 32 bits wide, and each one is carried on the 16-bit register bus as a pair of halves.

Software must write a magic key to the guard register before it can change any setting. Writing zero, or any other value, to the guard register protects the settings again. Writing the low half of the timeout requests a reload. The counter takes the new value on the next real-time tick. A busy flag stays set from the write until the second tick after that reload, so software can tell when the load has been applied. The whole block runs on one clock, and `rtc_tick` marks the slow-clock edges.

Top module: `wdt_top`

## Requirements
- R1: After reset the guard is closed. Writing 0xE551 to the guard register (address 9) opens it. Writing any other value closes it. Reading address 9 returns 1 in bit 0 while the guard is open.
- R2: While the guard is closed, writes to the timeout, threshold, control (address 4) and clear registers are ignored. Reads work in either guard state.
- R3: The count is read as the high half at address 8 and the low half at address 7. The full value is (high << 16) | low, and a borrow across the 16-bit boundary shows up in both halves.
- R4: The timeout is written as a high half (address 0) and a low half (address 1). The threshold is written as a high half (address 2) and a low half (address 3). A write to address 1 starts a load, and the counter takes the new timeout on the next tick.
- R5: Status bit 1 (address 6) reports load-busy. It is set from the address-1 write until the second tick after the reload.
- R6: The counter decrements by one only on a tick while control bit 0 (enable) is set. It holds its value when there is no tick or when enable is clear. It stays at zero after expiry until the next reload.
- R7: When a decrement makes the count equal to the threshold, status bit 0 is set, whether or not interrupts are enabled. `irq_o` equals status bit 0 AND control bit 1 (interrupt enable).
- R8: Writing 1 to bit 0 of the clear register (address 5) clears status bit 0, but only while the guard is open.
- R9: When a decrement reaches zero while control bit 2 (reset enable) is set, `rst_req_o` is high for exactly one cycle.
- R10: Reset clears the count, the control register, the status bits and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle enable marking each slow-clock edge |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from address) |
| irq_o | output | 1 | Pretimeout interrupt |
| rst_req_o | output | 1 | One-cycle reset request at expiry |

## Verification
The counter is driven with several patterns: a load with enable clear, a load that crosses the 16-bit borrow boundary, idle cycles with no tick, and a short load that counts all the way to zero and then receives extra ticks. Each pattern separates a different fault. The first shows whether counting is gated by enable. The borrow case shows whether the two halves are put together correctly. The idle cycles show whether decrements are gated by the tick. The extra ticks show whether the counter holds at zero and whether the reset request is a single pulse. Guard behaviour is checked by attempting control, load and clear writes with the guard closed and reading back the affected state afterwards. The key is also tried against a wrong nonzero value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int HALF_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_TMO_HI = 4'd0;
    localparam logic [ADDR_W-1:0] A_TMO_LO = 4'd1;
    localparam logic [ADDR_W-1:0] A_PRE_HI = 4'd2;
    localparam logic [ADDR_W-1:0] A_PRE_LO = 4'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd4;
    localparam logic [ADDR_W-1:0] A_CLR    = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd8;
    localparam logic [ADDR_W-1:0] A_GUARD  = 4'd9;

    typedef struct packed {
        logic rst_en;
        logic irq_en;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int          DW  = 16,
    parameter logic [15:0] KEY = 16'hE551
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          guard_wr,
    input  logic [DW-1:0] wdata,
    output logic          open_o
);
    typedef struct packed {
        logic open;
    } guard_t;

    guard_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (guard_wr) begin
            st_d.open = (wdata == DW'(KEY));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W      = 32,
    parameter int BUSY_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             commit,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] pre_val,
    input  logic             en,
    input  logic             rst_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busy_o,
    output logic             raw_o,
    output logic             rst_req_o
);
    localparam int BW = $clog2(BUSY_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [BW-1:0]    busy_left;
        logic             raw;
        logic             rst;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (clr) begin
            st_d.raw = 1'b0;
        end
        if (commit) begin
            st_d.pend = 1'b1;
        end
        if (tick) begin
            if (st_q.pend) begin
                st_d.cnt       = load_val;
                st_d.pend      = commit;
                st_d.busy_left = BW'(BUSY_TICKS);
            end else begin
                if (st_q.busy_left != '0) begin
                    st_d.busy_left = st_q.busy_left - 1'b1;
                end
                if (en && st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_d.cnt == pre_val) st_d.raw = 1'b1;
                    if (st_d.cnt == '0 && rst_en) st_d.rst = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign busy_o    = st_q.pend | (st_q.busy_left != '0);
    assign raw_o     = st_q.raw;
    assign rst_req_o = st_q.rst;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int          HW         = HALF_W,
    parameter logic [15:0] KEY        = 16'hE551,
    parameter int          BUSY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HW-1:0]     bus_wdata,
    output logic [HW-1:0]     bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam int CNT_W = 2 * HW;

    typedef struct packed {
        logic [HW-1:0] tmo_hi;
        logic [HW-1:0] tmo_lo;
        logic [HW-1:0] pre_hi;
        logic [HW-1:0] pre_lo;
        ctrl_t         ctrl;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             unlocked;
    logic             wr_any, wr_ok, commit, clr;
    logic [CNT_W-1:0] cnt;
    logic             busy, raw;
    logic             ctrl_en, ctrl_ie, ctrl_re;

    assign wr_any = bus_sel & bus_wr;
    assign wr_ok  = wr_any & unlocked;
    assign commit = wr_ok & (bus_addr == A_TMO_LO);
    assign clr    = wr_ok & (bus_addr == A_CLR) & bus_wdata[0];

    wdt_guard #(.DW(HW), .KEY(KEY)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard_wr (wr_any & (bus_addr == A_GUARD)),
        .wdata    (bus_wdata),
        .open_o   (unlocked)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ok) begin
            case (bus_addr)
                A_TMO_HI: regs_d.tmo_hi = bus_wdata;
                A_TMO_LO: regs_d.tmo_lo = bus_wdata;
                A_PRE_HI: regs_d.pre_hi = bus_wdata;
                A_PRE_LO: regs_d.pre_lo = bus_wdata;
                A_CTRL:   regs_d.ctrl   = ctrl_t'(bus_wdata[2:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl_en = regs_q.ctrl.en;
    assign ctrl_ie = regs_q.ctrl.irq_en;
    assign ctrl_re = regs_q.ctrl.rst_en;

    wdt_count #(.CNT_W(CNT_W), .BUSY_TICKS(BUSY_TICKS)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rtc_tick),
        .commit    (commit),
        .load_val  ({regs_d.tmo_hi, regs_d.tmo_lo}),
        .pre_val   ({regs_q.pre_hi, regs_q.pre_lo}),
        .en        (ctrl_en),
        .rst_en    (ctrl_re),
        .clr       (clr),
        .cnt_o     (cnt),
        .busy_o    (busy),
        .raw_o     (raw),
        .rst_req_o (rst_req_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TMO_HI: bus_rdata = regs_q.tmo_hi;
            A_TMO_LO: bus_rdata = regs_q.tmo_lo;
            A_PRE_HI: bus_rdata = regs_q.pre_hi;
            A_PRE_LO: bus_rdata = regs_q.pre_lo;
            A_CTRL:   bus_rdata = HW'(regs_q.ctrl);
            A_STAT:   bus_rdata = HW'({busy, raw});
            A_CNT_LO: bus_rdata = cnt[HW-1:0];
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:HW];
            A_GUARD:  bus_rdata = HW'(unlocked);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = raw & ctrl_ie;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             unlocked,
    input logic             commit,
    input logic [CNT_W-1:0] cnt,
    input logic             busy,
    input logic             raw,
    input logic             ctrl_en,
    input logic             ctrl_ie,
    input logic             ctrl_re,
    input logic             irq,
    input logic             rst_req
);
    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R9
    rst_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0 && ctrl_re));
    // R6
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    // R6
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !busy && !commit) |=> cnt == '0);
    // R5
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);
    // R2
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable({ctrl_en, ctrl_ie, ctrl_re}));
    // R8
    locked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !unlocked) |=> raw);
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw && ctrl_ie));
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (rtc_tick),
    .unlocked (unlocked),
    .commit   (commit),
    .cnt      (cnt),
    .busy     (busy),
    .raw      (raw),
    .ctrl_en  (ctrl_en),
    .ctrl_ie  (ctrl_ie),
    .ctrl_re  (ctrl_re),
    .irq      (irq_o),
    .rst_req  (rst_req_o)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    logic        rst_req_o;

    int total = 0;
    int bad = 0;
    int rst_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdt_top dut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always @(negedge clk) if (rst_req_o) rst_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); rtc_tick = 1'b1;
        @(negedge clk); rtc_tick = 1'b0;
    endtask

    task automatic rd_cnt(output logic [31:0] c);
        logic [15:0] hi, lo;
        rd(4'd8, hi);
        rd(4'd7, lo);
        c = {hi, lo};
    endtask

    task automatic t_reset();
        logic [15:0] v;
        logic [31:0] c;
        rd(4'd9, v); chk("R10 guard closed", {16'd0, v}, 32'd0);
        rd(4'd6, v); chk("R10 status", {16'd0, v}, 32'd0);
        rd(4'd4, v); chk("R10 control", {16'd0, v}, 32'd0);
        rd_cnt(c);   chk("R10 count", c, 32'd0);
        chk("R10 outputs", {30'd0, irq_o, rst_req_o}, 32'd0);
    endtask

    task automatic t_locked();
        logic [15:0] v;
        logic [31:0] c;
        wr(4'd4, 16'h0007);
        rd(4'd4, v); chk("R2 locked control write", {16'd0, v}, 32'd0);
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h0009);
        rd(4'd6, v); chk("R2 locked load no busy", {16'd0, v}, 32'd0);
        tick();
        rd_cnt(c);   chk("R2 locked load no reload", c, 32'd0);
    endtask

    task automatic t_guard();
        logic [15:0] v;
        wr(4'd9, 16'h1234);
        rd(4'd9, v); chk("R1 wrong key stays closed", {16'd0, v}, 32'd0);
        wr(4'd9, 16'hE551);
        rd(4'd9, v); chk("R1 key opens", {16'd0, v}, 32'd1);
        wr(4'd9, 16'h1234);
        rd(4'd9, v); chk("R1 other value closes", {16'd0, v}, 32'd0);
        wr(4'd9, 16'hE551);
        wr(4'd9, 16'h0000);
        rd(4'd9, v); chk("R1 zero closes", {16'd0, v}, 32'd0);
    endtask

    task automatic t_load();
        logic [15:0] v;
        logic [31:0] c;
        wr(4'd9, 16'hE551);
        wr(4'd4, 16'h0000);
        wr(4'd0, 16'h0001);
        wr(4'd1, 16'h0005);
        rd(4'd6, v); chk("R5 busy after commit", {31'd0, v[1]}, 32'd1);
        rd_cnt(c);   chk("R4 no reload before tick", c, 32'd0);
        tick();
        rd_cnt(c);   chk("R4 reload on tick", c, 32'h0001_0005);
        rd(4'd6, v); chk("R5 busy at reload", {31'd0, v[1]}, 32'd1);
        tick();
        rd(4'd6, v); chk("R5 busy one tick after", {31'd0, v[1]}, 32'd1);
        tick();
        rd(4'd6, v); chk("R5 busy cleared two ticks after", {31'd0, v[1]}, 32'd0);
        rd_cnt(c);   chk("R6 no decrement while disabled", c, 32'h0001_0005);
    endtask

    task automatic t_borrow();
        logic [15:0] v;
        logic [31:0] c;
        wr(4'd2, 16'hFFFF);
        wr(4'd3, 16'hFFFF);
        wr(4'd4, 16'h0001);
        wr(4'd0, 16'h0001);
        wr(4'd1, 16'h0000);
        tick();
        rd_cnt(c); chk("R3 loaded value", c, 32'h0001_0000);
        tick();
        rd(4'd8, v); chk("R3 high half after borrow", {16'd0, v}, 32'd0);
        rd(4'd7, v); chk("R3 low half after borrow", {16'd0, v}, 32'h0000_FFFF);
        rd(4'd6, v); chk("R7 no status off threshold", {31'd0, v[0]}, 32'd0);
        wr(4'd4, 16'h0000);
    endtask

    task automatic t_pretimeout();
        logic [15:0] v;
        logic [31:0] c;
        wr(4'd2, 16'h0001);
        wr(4'd3, 16'h0003);
        wr(4'd0, 16'h0001);
        wr(4'd1, 16'h0005);
        wr(4'd4, 16'h0001);
        tick();
        tick();
        rd_cnt(c);   chk("R6 decrement on tick", c, 32'h0001_0004);
        rd(4'd6, v); chk("R7 status before threshold", {31'd0, v[0]}, 32'd0);
        tick();
        rd(4'd6, v); chk("R7 status at threshold", {31'd0, v[0]}, 32'd1);
        chk("R7 irq masked", {31'd0, irq_o}, 32'd0);
        wr(4'd4, 16'h0003);
        #1 chk("R7 irq when enabled", {31'd0, irq_o}, 32'd1);
        repeat (4) @(negedge clk);
        rd_cnt(c);   chk("R6 hold without tick", c, 32'h0001_0003);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(4'd9, 16'h0000);
        wr(4'd5, 16'h0001);
        rd(4'd6, v); chk("R8 locked clear ignored", {31'd0, v[0]}, 32'd1);
        chk("R8 irq still high", {31'd0, irq_o}, 32'd1);
        wr(4'd9, 16'hE551);
        wr(4'd5, 16'h0001);
        rd(4'd6, v); chk("R8 clear when open", {31'd0, v[0]}, 32'd0);
        chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_expiry();
        logic [31:0] c;
        wr(4'd4, 16'h0000);
        wr(4'd2, 16'h0000);
        wr(4'd3, 16'h0001);
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h0003);
        wr(4'd4, 16'h0007);
        rst_seen = 0;
        tick();
        tick();
        tick();
        chk("R9 no reset before zero", rst_seen, 0);
        chk("R7 irq at threshold 1", {31'd0, irq_o}, 32'd1);
        tick();
        rd_cnt(c); chk("R6 reached zero", c, 32'd0);
        chk("R9 one reset pulse", rst_seen, 1);
        tick();
        tick();
        rd_cnt(c); chk("R6 holds at zero", c, 32'd0);
        chk("R9 no further pulses", rst_seen, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_guard();
        t_load();
        t_borrow();
        t_pretimeout();
        t_clear();
        t_expiry();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule